// File: doc/BRIEF.md
# DSD-over-PCM Marker Detector

This block watches a stream of stereo 32-bit PCM frames and decides whether the stream actually carries DSD-over-PCM (DoP) data. Each frame arrives as a one-cycle strobe together with a left word and a right word. The top byte of each word is the marker byte. When DoP data is present, both channels carry the same marker byte, and that byte alternates between 0x05 and 0xFA from one frame to the next. The lower 24 bits carry the payload and play no part in detection.

The block locks into DSD mode after a run of 32 consecutive frames that carry the correct alternating marker. In DSD mode it tolerates a frame whose left marker equals the complement of the expected marker. Any other broken frame returns it to PCM mode. While DSD mode is active, a gate output stops samples from being forwarded to an S/PDIF transmitter. A one-cycle pulse marks every mode change so that downstream logic can reconfigure.

Top module: `dop_detect`

## Requirements
- R1: During and after a synchronous active-high reset, the block is in PCM mode (`dsd_mode` = 0), `mode_pulse` is 0, the run count is zero and the expected marker is 0x05.
- R2: The marker byte of a word is its bits 31:24. Bits 23:0 have no influence on detection, and a marker value placed in the lower bits does not count.
- R3: A frame matches only when both the left marker byte and the right marker byte equal the expected marker. The expected marker starts at 0x05 and is inverted (0x05 becomes 0xFA, and 0xFA becomes 0x05) after each matching frame.
- R4: In PCM mode, the 32nd consecutive matching frame switches the block to DSD mode. `dsd_mode` reads 1 in the cycle after the clock edge that captured that frame. After 31 matching frames it still reads 0.
- R5: A non-matching frame clears the run count and leaves the expected marker unchanged, so a fresh run must begin with the value that was expected when the frame arrived.
- R6: In DSD mode, a non-matching frame whose left marker equals the complement of the expected marker keeps the block in DSD mode.
- R7: In DSD mode, any other non-matching frame returns the block to PCM mode. Another 32 consecutive matches are then needed to re-enter DSD mode.
- R8: `spdif_fwd_en` is 0 exactly while `dsd_mode` is 1.
- R9: `mode_pulse` is high for exactly one cycle per mode change: the first cycle in which `dsd_mode` shows its new value.
- R10: In cycles without `frame_vld`, the mode, run count and expected marker hold their values. Idle gaps between frames therefore do not break a run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_vld | input | 1 | One frame is present on the sample inputs this cycle |
| samp_l | input | 32 | Left sample word |
| samp_r | input | 32 | Right sample word |
| dsd_mode | output | 1 | 1 while the stream is treated as DSD-over-PCM |
| mode_pulse | output | 1 | One-cycle pulse on each mode change |
| spdif_fwd_en | output | 1 | 1 when samples may be forwarded to the S/PDIF transmitter |

## Verification
Lock-in is tried with clean alternating runs, which have varying payload bits and idle gaps, and is probed at 31 and 32 frames to pin down the threshold. Broken runs, where the left channel alone, the right channel alone, or the upper byte is wrong while the marker sits in the lower bits, separate "count cleared and marker kept" from "marker advanced" and from "payload looked at". In DSD mode, complement-left frames are contrasted with other broken frames (one with a correct left and a wrong right) to separate the tolerance rule from exit. A long DSD run checks that count saturation never drops the mode.

// File: rtl/dop_detect.sv
module dop_detect #(
  parameter int WORD_W      = 32,
  parameter int MARK_W      = 8,
  parameter int LOCK_FRAMES = 32,
  parameter int CNT_W       = 6,
  parameter logic [MARK_W-1:0] MARK_A = 8'h05
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_vld,
  input  logic [WORD_W-1:0] samp_l,
  input  logic [WORD_W-1:0] samp_r,
  output logic              dsd_mode,
  output logic              mode_pulse,
  output logic              spdif_fwd_en
);
  localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] LOCK_C  = CNT_W'(LOCK_FRAMES);

  logic [MARK_W-1:0] exp_mk;
  logic [CNT_W-1:0]  run_cnt;
  logic              dsd_q, pulse_q;

  logic [MARK_W-1:0] mk_l, mk_r;
  logic              hit, hold, lock, drop, dsd_nx;
  logic [CNT_W-1:0]  cnt_inc;

  assign mk_l    = samp_l[WORD_W-1 -: MARK_W];
  assign mk_r    = samp_r[WORD_W-1 -: MARK_W];
  assign hit     = (mk_l == exp_mk) && (mk_r == exp_mk);
  assign hold    = (mk_l == ~exp_mk);
  assign cnt_inc = (run_cnt == CNT_TOP) ? run_cnt : run_cnt + 1'b1;
  assign lock    = !dsd_q && hit && (cnt_inc >= LOCK_C);
  assign drop    = dsd_q && !hit && !hold;

  always_comb begin
    dsd_nx = dsd_q;
    if (frame_vld && lock) dsd_nx = 1'b1;
    else if (frame_vld && drop) dsd_nx = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      exp_mk  <= MARK_A;
      run_cnt <= '0;
      dsd_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= (dsd_nx != dsd_q);
      dsd_q   <= dsd_nx;
      if (frame_vld) begin
        if (hit) begin
          exp_mk  <= ~exp_mk;
          run_cnt <= lock ? '0 : cnt_inc;
        end else begin
          run_cnt <= '0;
        end
      end
    end
  end

  assign dsd_mode     = dsd_q;
  assign mode_pulse   = pulse_q;
  assign spdif_fwd_en = !dsd_q;

  assert_marker_legal_R3: assert property (@(posedge clk) disable iff (rst)
    (exp_mk == MARK_A) || (exp_mk == ~MARK_A));

  assert_miss_clears_R5: assert property (@(posedge clk) disable iff (rst)
    frame_vld && !hit |=> (run_cnt == '0) && $stable(exp_mk));

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !frame_vld |=> $stable(dsd_q) && $stable(run_cnt) && $stable(exp_mk));

  assert_entry_count_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(dsd_q) |-> $past(frame_vld) && ($past(run_cnt) == LOCK_C - 1'b1));

  assert_tolerate_R6: assert property (@(posedge clk) disable iff (rst)
    frame_vld && dsd_q && hold |=> dsd_q);

  assert_exit_frame_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(dsd_q) |-> $past(frame_vld));

  assert_pulse_edge_R9: assert property (@(posedge clk) disable iff (rst)
    pulse_q |-> (dsd_q != $past(dsd_q)));

  assert_pulse_single_R9: assert property (@(posedge clk) disable iff (rst)
    pulse_q |=> !pulse_q);
endmodule

// File: tb/dop_detect_tb.sv
`timescale 1ns/1ps
module dop_detect_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        frame_vld = 1'b0;
  logic [31:0] samp_l = '0, samp_r = '0;
  logic        dsd_mode, mode_pulse, spdif_fwd_en;

  int total = 0, bad = 0, seed = 1;
  logic [7:0] exp_mk;

  always #2 clk = ~clk;

  dop_detect dut_i (
    .clk(clk), .rst(rst), .frame_vld(frame_vld), .samp_l(samp_l), .samp_r(samp_r),
    .dsd_mode(dsd_mode), .mode_pulse(mode_pulse), .spdif_fwd_en(spdif_fwd_en)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, expv);
    end
  endtask

  task automatic chk_out(input string req, input logic d, input logic p);
    check(dsd_mode == d, {req, " dsd_mode"}, dsd_mode, d);
    check(mode_pulse == p, {req, " mode_pulse"}, mode_pulse, p);
    check(spdif_fwd_en == !d, "R8 spdif_fwd_en", spdif_fwd_en, !d);
  endtask

  function automatic logic [23:0] lo();
    seed = seed * 1103515245 + 12345;
    return 24'(seed);
  endfunction

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    exp_mk = 8'h05;
  endtask

  task automatic send(input logic [31:0] l, input logic [31:0] r, input int gap);
    @(negedge clk); frame_vld = 1'b1; samp_l = l; samp_r = r;
    @(negedge clk); frame_vld = 1'b0; samp_l = {8'hA5, lo()}; samp_r = {exp_mk, lo()};
    for (int g = 0; g < gap; g++) @(negedge clk);
  endtask

  task automatic send_good(input int gap);
    send({exp_mk, lo()}, {exp_mk, lo()}, gap);
    exp_mk = ~exp_mk;
  endtask

  task automatic run_good(input int n);
    for (int i = 0; i < n; i++) send_good(i % 3);
  endtask

  task automatic t_reset();
    do_reset();
    chk_out("R1 reset", 1'b0, 1'b0);
  endtask

  task automatic t_lock();
    do_reset();
    run_good(31);
    chk_out("R4 after 31", 1'b0, 1'b0);
    send_good(0);
    chk_out("R4 after 32", 1'b1, 1'b1);
    @(negedge clk);
    chk_out("R9 pulse one cycle", 1'b1, 1'b0);
    for (int g = 0; g < 5; g++) @(negedge clk);
    chk_out("R10 idle hold", 1'b1, 1'b0);
  endtask

  task automatic t_restart();
    do_reset();
    run_good(20);
    send({exp_mk, lo()}, {8'h00, lo()}, 0);
    run_good(31);
    chk_out("R5 right miss clears count", 1'b0, 1'b0);
    send_good(0);
    chk_out("R5 marker kept", 1'b1, 1'b1);
    do_reset();
    run_good(17);
    send({~exp_mk, lo()}, {exp_mk, lo()}, 1);
    run_good(31);
    chk_out("R5 left miss clears count", 1'b0, 1'b0);
    send_good(0);
    chk_out("R5 left miss marker kept", 1'b1, 1'b1);
  endtask

  task automatic t_field();
    do_reset();
    run_good(31);
    send({8'h00, exp_mk, exp_mk, exp_mk}, {8'h00, exp_mk, exp_mk, exp_mk}, 0);
    chk_out("R2 lower-bit marker ignored", 1'b0, 1'b0);
    run_good(31);
    chk_out("R2 count cleared by upper byte", 1'b0, 1'b0);
    send_good(0);
    chk_out("R2 lock with payload bits", 1'b1, 1'b1);
  endtask

  task automatic t_tolerate_exit();
    do_reset();
    run_good(32);
    send({~exp_mk, lo()}, {8'h33, lo()}, 0);
    chk_out("R6 complement left stays", 1'b1, 1'b0);
    run_good(3);
    send({~exp_mk, lo()}, {~exp_mk, lo()}, 2);
    chk_out("R6 complement both stays", 1'b1, 1'b0);
    run_good(70);
    chk_out("R6 long DSD run", 1'b1, 1'b0);
    send({8'h12, lo()}, {exp_mk, lo()}, 0);
    chk_out("R7 exit", 1'b0, 1'b1);
    @(negedge clk);
    chk_out("R9 exit pulse one cycle", 1'b0, 1'b0);
    run_good(31);
    chk_out("R7 relock needs 32", 1'b0, 1'b0);
    send_good(0);
    chk_out("R7 relock", 1'b1, 1'b1);
    send({exp_mk, lo()}, {8'h77, lo()}, 0);
    chk_out("R7 exit on right miss", 1'b0, 1'b1);
  endtask

  initial begin
    exp_mk = 8'h05;
    t_reset();
    t_lock();
    t_restart();
    t_field();
    t_tolerate_exit();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    total++; bad++;
    $display("FAIL watchdog act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule